// File: doc/BRIEF.md
# Vectored Level-Sensitive Interrupt Controller

This block collects up to 128 level-sensitive interrupt lines, grouped in banks of 32, and presents one chosen interrupt to a CPU. Software reaches it through a plain 32-bit register bus: an address, a write strobe, write data, and read data that is returned one clock after the address is presented. Each bank owns a mask register, which software changes through a set alias and a clear alias so that no read-modify-write is needed, and a pending view that shows which unmasked inputs are currently high.

A sorter looks at every unmasked, asserted source whose 6-bit priority passes a programmable threshold, picks the best one, and latches its number. While a number is latched the CPU interrupt output is high and the number is readable from the active-number register. The latch holds until software writes the acknowledge bit. The sorter then picks afresh on the following cycle, which also discards a selection whose source was masked or dropped while it waited. A soft reset bit returns all state to its reset values and reports completion through a status flag. A revision register, a read/write autoidle bit and a read/write protection flag are kept as plain storage.

Top module: `vic_ctrl`

## Requirements
- R1: The controller has NUM_SRC/32 banks. Bank n's mask reads at byte address 0x84+0x20*n and its pending view at 0x98+0x20*n; source s lives in bank s/32 at bit s%32.
- R2: A write to 0x88+0x20*n clears the mask bits of bank n where the write data is 1 (enabling those sources); write data bits that are 0 leave their mask bits unchanged.
- R3: A write to 0x8C+0x20*n sets the mask bits of bank n where the write data is 1 (disabling those sources); write data bits that are 0 leave their mask bits unchanged.
- R4: A pending view reads as the bank's inputs ANDed with the inverse of its mask, follows the inputs level by level, and ignores priority and threshold.
- R5: Address 0x00 reads REV_MAJOR in bits [7:4] and REV_MINOR in bits [3:0], zero above.
- R6: Source s has a level register at 0x100+4*s holding a priority in bits [7:2] (bits [1:0] read 0). The threshold register at 0x68 holds 7 bits [6:0]; a threshold of 0 filters nothing, otherwise a source takes part in sorting only if its priority is numerically less than the threshold.
- R7: Among eligible sources the smallest priority value wins, ties going to the lowest source number. When nothing is latched, an eligible source is latched on the next clock edge; irq_o is high exactly while a selection is latched, and 0x40 reads the latched number in bits [6:0] (0 when none).
- R8: A latched selection and irq_o stay unchanged, whatever the inputs, masks or priorities do, until a write to 0x48 with bit 0 set; a write to 0x48 with bit 0 clear has no effect.
- R9: The acknowledge drops the selection on its own clock edge, so irq_o is low for the following cycle; the next selection is latched on the edge after that. A selection whose source was masked or deasserted is simply discarded by the acknowledge.
- R10: Writing 1 to bit 1 of 0x10 starts a soft reset lasting one cycle; bit 0 of 0x14 reads 0 during that cycle and 1 otherwise. Bit 0 of 0x10 is a read/write autoidle flag; bit 1 reads 0.
- R11: After hardware or soft reset all mask bits are 1, level, threshold, autoidle and protection registers are 0, and nothing is latched. Bit 0 of 0x4C is a read/write protection flag that changes no other behaviour.
- R12: rd_data_o shows, one cycle later, the register at the address presented on the previous clock edge; unmapped addresses and the control register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe for the current cycle |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data for the previous cycle's address |
| src_i | input | NUM_SRC | Level-sensitive interrupt inputs |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the controller with NUM_SRC set to 128 instead of the default 96, so a fourth bank exists and the highest mask, pending and level addresses (bank 3 at 0xE4/0xE8/0xEC/0xF8, level register 0x2FC) are exercised along with source number 127 in the seven-bit active field. REV_MAJOR and REV_MINOR are set to 2 and 1 so the two revision nibbles are distinguishable. With four banks in play, the priority tie between sources in bank 2 and bank 3 exercises the cross-bank tie-break, not only the one inside a bank.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int BANK_W = 32;   // sources per bank
  localparam int PRIO_W = 6;    // priority field width
  localparam int THR_W  = 7;    // threshold field width
  localparam int NUM_W  = 7;    // active-number field width
  localparam int LIDX_W = 5;    // index inside a bank

  // register map (byte offsets)
  localparam int A_REV    = 'h000;
  localparam int A_CFG    = 'h010;
  localparam int A_STAT   = 'h014;
  localparam int A_ACT    = 'h040;
  localparam int A_CTRL   = 'h048;
  localparam int A_PROT   = 'h04C;
  localparam int A_THR    = 'h068;
  localparam int A_MASK0  = 'h084;
  localparam int A_MCLR0  = 'h088;
  localparam int A_MSET0  = 'h08C;
  localparam int A_PEND0  = 'h098;
  localparam int A_LVL0   = 'h100;
  localparam int BANK_STR = 'h020;

  typedef struct packed {
    logic              found;
    logic [LIDX_W-1:0] idx;
    logic [PRIO_W-1:0] prio;
  } bank_win_t;
endpackage

// File: rtl/vic_level_regs.sv
module vic_level_regs
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 96
) (
  input  logic                      clk_i,
  input  logic                      clr_i,
  input  logic                      we_i,
  input  logic [NUM_W-1:0]          idx_i,
  input  logic [PRIO_W-1:0]         wprio_i,
  output logic [NUM_SRC*PRIO_W-1:0] prio_o
);
  logic [PRIO_W-1:0] lvl_q [NUM_SRC];

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      for (int i = 0; i < NUM_SRC; i++) lvl_q[i] <= '0;
    end else if (we_i) begin
      lvl_q[idx_i] <= wprio_i;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flat
    assign prio_o[g*PRIO_W +: PRIO_W] = lvl_q[g];
  end

  // R6: a level write lands in the addressed entry
  assert_lvl_write_R6: assert property (@(posedge clk_i) disable iff (clr_i)
    we_i |=> (lvl_q[$past(idx_i)] == $past(wprio_i)));
endmodule

// File: rtl/vic_bank.sv
module vic_bank
  import vic_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     clr_i,
  input  logic                     set_we_i,
  input  logic                     clr_we_i,
  input  logic [BANK_W-1:0]        wdata_i,
  input  logic [BANK_W-1:0]        src_i,
  input  logic [BANK_W*PRIO_W-1:0] prio_i,
  input  logic [THR_W-1:0]         thr_i,
  output logic [BANK_W-1:0]        mask_o,
  output logic [BANK_W-1:0]        pend_o,
  output bank_win_t                win_o
);
  logic [BANK_W-1:0] mask_q;
  logic [BANK_W-1:0] elig;
  logic [BANK_W-1:0] set_bits, clr_bits;

  assign set_bits = set_we_i ? wdata_i : '0;
  assign clr_bits = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i) begin
    if (clr_i) mask_q <= '1;
    else       mask_q <= (mask_q | set_bits) & ~clr_bits;
  end

  assign mask_o = mask_q;
  assign pend_o = src_i & ~mask_q;

  always_comb begin
    for (int i = 0; i < BANK_W; i++) begin
      elig[i] = pend_o[i] &&
                ((thr_i == '0) || ({1'b0, prio_i[i*PRIO_W +: PRIO_W]} < thr_i));
    end
  end

  // lowest index wins ties because only a strictly better priority replaces
  always_comb begin
    win_o = '0;
    for (int i = 0; i < BANK_W; i++) begin
      if (elig[i] && (!win_o.found || (prio_i[i*PRIO_W +: PRIO_W] < win_o.prio))) begin
        win_o.found = 1'b1;
        win_o.idx   = LIDX_W'(i);
        win_o.prio  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  // R2: cleared bits read back as 0
  assert_mask_clear_R2: assert property (@(posedge clk_i) disable iff (clr_i)
    (clr_we_i && !set_we_i) |=> ((mask_q & $past(wdata_i)) == '0));
  // R3: set bits read back as 1
  assert_mask_set_R3: assert property (@(posedge clk_i) disable iff (clr_i)
    (set_we_i && !clr_we_i) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));
  // R7: a bank winner is an unmasked asserted input
  assert_win_live_R7: assert property (@(posedge clk_i) disable iff (clr_i)
    win_o.found |-> (src_i[win_o.idx] && !mask_q[win_o.idx]));
  // R6: a bank winner passes a nonzero threshold
  assert_win_thr_R6: assert property (@(posedge clk_i) disable iff (clr_i)
    (win_o.found && thr_i != '0) |-> ({1'b0, win_o.prio} < thr_i));
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC   = 96,
  parameter int ADDR_W    = 12,
  parameter int REV_MAJOR = 1,
  parameter int REV_MINOR = 0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic              irq_o
);
  localparam int NBANK   = NUM_SRC / BANK_W;
  localparam int LVL_END = A_LVL0 + 4 * NUM_SRC;

  // ---------------- control state ----------------
  logic              srst_q, done_q, autoidle_q, prot_q;
  logic [THR_W-1:0]  thr_q;
  logic              act_valid_q;
  logic [NUM_W-1:0]  act_num_q;
  logic [31:0]       rd_data_q;
  logic              clr;

  assign clr = rst_i | srst_q;

  // ---------------- address decode ----------------
  logic ack_we, cfg_we, lvl_hit, lvl_we;
  logic [NUM_W-1:0] lvl_idx;
  logic [ADDR_W-1:0] lvl_off;

  assign ack_we  = wr_en_i && (addr_i == ADDR_W'(A_CTRL)) && wr_data_i[0];
  assign cfg_we  = wr_en_i && (addr_i == ADDR_W'(A_CFG));
  assign lvl_hit = (addr_i >= ADDR_W'(A_LVL0)) && (addr_i < ADDR_W'(LVL_END)) &&
                   (addr_i[1:0] == 2'b00);
  assign lvl_we  = wr_en_i && lvl_hit;
  assign lvl_off = addr_i - ADDR_W'(A_LVL0);
  assign lvl_idx = NUM_W'(lvl_off >> 2);

  // ---------------- level registers ----------------
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;

  vic_level_regs #(.NUM_SRC(NUM_SRC)) u_lvl (
    .clk_i  (clk_i),
    .clr_i  (clr),
    .we_i   (lvl_we),
    .idx_i  (lvl_idx),
    .wprio_i(wr_data_i[7:2]),
    .prio_o (prio_flat)
  );

  // ---------------- banks ----------------
  logic [NUM_SRC-1:0] mask_all, pend_all;
  bank_win_t          win_w [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic set_we, clr_we;
    assign clr_we = wr_en_i && (addr_i == ADDR_W'(A_MCLR0 + b * BANK_STR));
    assign set_we = wr_en_i && (addr_i == ADDR_W'(A_MSET0 + b * BANK_STR));

    vic_bank u_bank (
      .clk_i   (clk_i),
      .clr_i   (clr),
      .set_we_i(set_we),
      .clr_we_i(clr_we),
      .wdata_i (wr_data_i),
      .src_i   (src_i[b*BANK_W +: BANK_W]),
      .prio_i  (prio_flat[b*BANK_W*PRIO_W +: BANK_W*PRIO_W]),
      .thr_i   (thr_q),
      .mask_o  (mask_all[b*BANK_W +: BANK_W]),
      .pend_o  (pend_all[b*BANK_W +: BANK_W]),
      .win_o   (win_w[b])
    );
  end

  // ---------------- cross-bank sort ----------------
  logic              any_found;
  logic [PRIO_W-1:0] best_prio;
  logic [NUM_W-1:0]  best_num;

  always_comb begin
    any_found = 1'b0;
    best_prio = '0;
    best_num  = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (win_w[b].found && (!any_found || (win_w[b].prio < best_prio))) begin
        any_found = 1'b1;
        best_prio = win_w[b].prio;
        best_num  = NUM_W'(b * BANK_W) + NUM_W'(win_w[b].idx);
      end
    end
  end

  // ---------------- soft reset sequencing ----------------
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      srst_q <= 1'b0;
      done_q <= 1'b1;
    end else if (srst_q) begin
      srst_q <= 1'b0;
      done_q <= 1'b1;
    end else if (cfg_we && wr_data_i[1]) begin
      srst_q <= 1'b1;
      done_q <= 1'b0;
    end
  end

  // ---------------- plain storage ----------------
  always_ff @(posedge clk_i) begin
    if (clr) begin
      autoidle_q <= 1'b0;
      prot_q     <= 1'b0;
      thr_q      <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_W'(A_CFG))  autoidle_q <= wr_data_i[0];
      if (addr_i == ADDR_W'(A_PROT)) prot_q     <= wr_data_i[0];
      if (addr_i == ADDR_W'(A_THR))  thr_q      <= wr_data_i[THR_W-1:0];
    end
  end

  // ---------------- selection latch ----------------
  always_ff @(posedge clk_i) begin
    if (clr) begin
      act_valid_q <= 1'b0;
      act_num_q   <= '0;
    end else if (ack_we) begin
      act_valid_q <= 1'b0;
    end else if (!act_valid_q && any_found) begin
      act_valid_q <= 1'b1;
      act_num_q   <= best_num;
    end
  end

  assign irq_o = act_valid_q;

  // ---------------- read path ----------------
  logic [31:0] rd_n;

  always_comb begin
    rd_n = '0;
    if (addr_i == ADDR_W'(A_REV))  rd_n = {24'h0, 4'(REV_MAJOR), 4'(REV_MINOR)};
    if (addr_i == ADDR_W'(A_CFG))  rd_n = {31'h0, autoidle_q};
    if (addr_i == ADDR_W'(A_STAT)) rd_n = {31'h0, done_q};
    if (addr_i == ADDR_W'(A_ACT))  rd_n = act_valid_q ? {25'h0, act_num_q} : 32'h0;
    if (addr_i == ADDR_W'(A_PROT)) rd_n = {31'h0, prot_q};
    if (addr_i == ADDR_W'(A_THR))  rd_n = {25'h0, thr_q};
    for (int b = 0; b < NBANK; b++) begin
      if (addr_i == ADDR_W'(A_MASK0 + b * BANK_STR)) rd_n = mask_all[b*BANK_W +: BANK_W];
      if (addr_i == ADDR_W'(A_PEND0 + b * BANK_STR)) rd_n = pend_all[b*BANK_W +: BANK_W];
    end
    if (lvl_hit) rd_n = {24'h0, prio_flat[int'(lvl_idx)*PRIO_W +: PRIO_W], 2'b00};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rd_data_q <= '0;
    else       rd_data_q <= rd_n;
  end

  assign rd_data_o = rd_data_q;

  // ---------------- assertions ----------------
  // R8: a latched selection is held until acknowledged
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (act_valid_q && !ack_we && !srst_q) |=> (act_valid_q && act_num_q == $past(act_num_q)));
  // R9: the acknowledge empties the latch on its own edge
  assert_ack_drop_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    ack_we |=> !irq_o);
  // R7: the latch only fills when the sorter offered a candidate
  assert_fill_src_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(act_valid_q) |-> $past(any_found));
  // R10: a soft reset leaves the reset state and the done flag behind
  assert_soft_reset_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    srst_q |=> (done_q && !irq_o && thr_q == '0 && (&mask_all)));
  // R10: done is low only during the soft reset cycle
  assert_done_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    !done_q |-> srst_q);
endmodule

// File: tb/sim_vic_ctrl.sv
`timescale 1ns/1ps
module sim_vic_ctrl;
  localparam int NSRC = 128;
  localparam int AW   = 12;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [AW-1:0]   addr = '0;
  logic            we = 1'b0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NSRC-1:0] src = '0;
  logic            irq;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  vic_ctrl #(.NUM_SRC(NSRC), .ADDR_W(AW), .REV_MAJOR(2), .REV_MINOR(1)) u0 (
    .clk_i(clk), .rst_i(rst), .addr_i(addr), .wr_en_i(we), .wr_data_i(wdata),
    .rd_data_o(rdata), .src_i(src), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    @(posedge clk); #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  // {op(1=write), req, addr, data, expected}
  localparam int NV = 26;
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 4'd5,  12'h000, 32'h0,        32'h0000_0021}, // R5 revision nibbles
    {1'b0, 4'd11, 12'h084, 32'h0,        32'hFFFF_FFFF}, // R11 masks reset to ones
    {1'b0, 4'd4,  12'h098, 32'h0,        32'h0000_0000}, // R4 all masked
    {1'b1, 4'd2,  12'h088, 32'h0000_00FF, 32'h0},        // R2 clear low byte
    {1'b0, 4'd2,  12'h084, 32'h0,        32'hFFFF_FF00}, // R2
    {1'b0, 4'd4,  12'h098, 32'h0,        32'h0000_0001}, // R4 src & ~mask
    {1'b1, 4'd3,  12'h08C, 32'h0000_000F, 32'h0},        // R3 set low nibble
    {1'b0, 4'd3,  12'h084, 32'h0,        32'hFFFF_FF0F}, // R3
    {1'b0, 4'd4,  12'h098, 32'h0,        32'h0000_0000}, // R4
    {1'b1, 4'd1,  12'h0E8, 32'hFFFF_FFFF, 32'h0},        // R1 bank 3 clear
    {1'b0, 4'd1,  12'h0F8, 32'h0,        32'hF000_000F}, // R1 bank 3 pending
    {1'b1, 4'd3,  12'h0EC, 32'hF000_0000, 32'h0},        // R3 bank 3 set
    {1'b0, 4'd3,  12'h0E4, 32'h0,        32'hF000_0000}, // R3
    {1'b0, 4'd1,  12'h0F8, 32'h0,        32'h0000_000F}, // R1
    {1'b0, 4'd1,  12'h0B8, 32'h0,        32'h0000_0000}, // R1 bank 1 untouched
    {1'b1, 4'd6,  12'h114, 32'hFFFF_FFFF, 32'h0},        // R6 level write
    {1'b0, 4'd6,  12'h114, 32'h0,        32'h0000_00FC}, // R6 bits [7:2] only
    {1'b1, 4'd6,  12'h068, 32'hFFFF_FFFF, 32'h0},        // R6 threshold write
    {1'b0, 4'd6,  12'h068, 32'h0,        32'h0000_007F}, // R6
    {1'b1, 4'd11, 12'h04C, 32'h0000_0003, 32'h0},        // R11 protection
    {1'b0, 4'd11, 12'h04C, 32'h0,        32'h0000_0001}, // R11
    {1'b1, 4'd10, 12'h010, 32'h0000_0001, 32'h0},        // R10 autoidle
    {1'b0, 4'd10, 12'h010, 32'h0,        32'h0000_0001}, // R10
    {1'b0, 4'd10, 12'h014, 32'h0,        32'h0000_0001}, // R10 done idle high
    {1'b0, 4'd12, 12'h020, 32'h0,        32'h0000_0000}, // R12 unmapped
    {1'b0, 4'd12, 12'h048, 32'h0,        32'h0000_0000}  // R12 control reads 0
  };

  initial begin : watchdog
    #(200000 * 8);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    idle(4);
    rst = 1'b0;
    idle(1);

    // reset state R11
    check("R11 irq after reset", {31'h0, irq}, 32'h0);
    rd(12'h040, d); check("R11 active after reset", d, 32'h0);
    rd(12'h068, d); check("R11 threshold after reset", d, 32'h0);

    // vector table
    src = {32'hF000_000F, 32'h0000_8001, 32'h1234_5678, 32'h8000_0001};
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][80]) begin
        wr(VEC[v][75:64], VEC[v][63:32]);
      end else begin
        rd(VEC[v][75:64], d);
        check($sformatf("R%0d vec %0d", VEC[v][79:76], v), d, VEC[v][31:0]);
      end
    end

    // soft reset R10
    src = '0;
    wr(12'h010, 32'h2);
    rd(12'h014, d); check("R10 done low in reset cycle", d, 32'h0);
    rd(12'h014, d); check("R10 done high after", d, 32'h1);
    rd(12'h010, d); check("R10 cfg cleared", d, 32'h0);
    rd(12'h084, d); check("R10 mask0 ones", d, 32'hFFFF_FFFF);
    rd(12'h0E4, d); check("R10 mask3 ones", d, 32'hFFFF_FFFF);
    rd(12'h114, d); check("R10 level cleared", d, 32'h0);
    rd(12'h04C, d); check("R10 protection cleared", d, 32'h0);
    check("R10 irq low", {31'h0, irq}, 32'h0);

    // sorter R7: 40->5, 70->3, 100->3
    wr(12'h088, 32'hFFFF_FFFF); wr(12'h0A8, 32'hFFFF_FFFF);
    wr(12'h0C8, 32'hFFFF_FFFF); wr(12'h0E8, 32'hFFFF_FFFF);
    wr(12'h1A0, 32'h14); wr(12'h218, 32'h0C); wr(12'h290, 32'h0C); wr(12'h2FC, 32'h00);
    src[40] = 1'b1; src[70] = 1'b1; src[100] = 1'b1;
    idle(2);
    check("R7 irq raised", {31'h0, irq}, 32'h1);
    rd(12'h040, d); check("R7 tie to lowest number", d, 32'd70);

    // hold R8
    src[127] = 1'b1;
    idle(2);
    rd(12'h040, d); check("R8 held against better source", d, 32'd70);
    wr(12'h048, 32'h2);
    idle(1);
    rd(12'h040, d); check("R8 write without bit0 ignored", d, 32'd70);
    check("R8 irq stays", {31'h0, irq}, 32'h1);

    // acknowledge timing R9
    wr(12'h048, 32'h1);
    check("R9 irq low after ack", {31'h0, irq}, 32'h0);
    @(posedge clk); #1;
    check("R9 reselect next cycle", {31'h0, irq}, 32'h1);
    rd(12'h040, d); check("R7 best priority wins", d, 32'd127);

    // stale selection R9
    src[127] = 1'b0;
    rd(12'h040, d); check("R8 stale kept until ack", d, 32'd127);
    wr(12'h048, 32'h1);
    idle(1);
    rd(12'h040, d); check("R9 stale dropped", d, 32'd70);
    src = '0;
    wr(12'h048, 32'h1);
    idle(2);
    check("R9 nothing left", {31'h0, irq}, 32'h0);
    rd(12'h040, d); check("R7 active reads 0 when none", d, 32'h0);

    // threshold R6
    wr(12'h068, 32'h4);
    src[40] = 1'b1;
    idle(3);
    check("R6 filtered by threshold", {31'h0, irq}, 32'h0);
    rd(12'h0B8, d); check("R4 pending ignores threshold", d, 32'h0000_0100);
    wr(12'h068, 32'h6);
    idle(2);
    rd(12'h040, d); check("R6 passes raised threshold", d, 32'd40);
    src = '0;
    wr(12'h048, 32'h1);
    idle(2);

    // level following R4
    src[70] = 1'b1;
    rd(12'h0D8, d); check("R4 pending follows input high", d, 32'h0000_0040);
    src[70] = 1'b0;
    rd(12'h0D8, d); check("R4 pending follows input low", d, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule